// File: doc/BRIEF.md
# Flag-Setting Integer ALU

This block is an integer arithmetic and logic unit for a processor datapath. Each cycle in which `op_valid` is high, it takes an opcode, a width select and two operands. It computes add, subtract, AND, OR or XOR at a width of 8, 16 or 32 bits. The result and its write strobe are registered, and they appear in the cycle after the operation is presented.

The unit holds four single-bit condition flags: carry, zero, sign and overflow. Two operations, compare and test, work only on these flags. Compare does a subtraction and test does an AND, but neither asks for the result to be written. A third operation, address-add, does the reverse: it writes a sum and leaves the flags alone. A condition evaluator reads the stored flags. It drives a byte that is exactly 0 or 1 for the selected condition, plus a 32-bit zero-extended copy of that byte.

Top module: `flag_alu`

## Requirements
- R1: After reset the result is 0, `result_we` is 0 and all four flags are 0.
- R2: Opcode encodings are 0 add, 1 subtract, 2 AND, 3 OR, 4 XOR, 5 compare, 6 test and 7 address-add. Width encodings are 0 for 8 bits, 1 for 16 bits, and 2 or 3 for 32 bits. Operand bits above the selected width are ignored, and the result bits above it are zero.
- R3: For add, carry is the carry out of the top bit of the selected width. For subtract and compare, carry is set when the first operand is unsigned-less than the second (a borrow).
- R4: Zero is set when the result at the selected width is zero. Sign equals the top bit of the result at that width.
- R5: Overflow is set on two's-complement overflow of add, subtract or compare, in either direction. AND, OR, XOR and test clear both carry and overflow.
- R6: Compare and test update all four flags exactly as subtract and AND do. They leave `result_we` low and the result register unchanged.
- R7: Address-add writes its sum with `result_we` high and leaves all four flags unchanged.
- R8: When `op_valid` is low, the flags and the result hold and `result_we` is low. Result, `result_we` and flags change on the clock edge after a valid operation.
- R9: Condition codes select the following:
  - 0: Z
  - 1: !Z
  - 2: S^O
  - 3: !(S^O)
  - 4: (S^O)|Z
  - 5: !((S^O)|Z)
  - 6: C
  - 7: !C
  - 8: C|Z
  - 9: !(C|Z)
  - 10: S
  - 11: !S
  - 12 to 15: always 0
  
  The evaluation is combinational from the stored flags.
- R10: `set_byte` is always 0 or 1, and `set_wide` equals it zero-extended, with its upper 24 bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 3 | Operation select |
| op_width | input | 2 | Operand width select |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| cond_sel | input | 4 | Condition to evaluate |
| result | output | 32 | Registered result |
| result_we | output | 1 | Result write strobe |
| flag_c | output | 1 | Carry / borrow flag |
| flag_z | output | 1 | Zero flag |
| flag_s | output | 1 | Sign flag |
| flag_o | output | 1 | Overflow flag |
| set_byte | output | 8 | Condition value, 0 or 1 |
| set_wide | output | 32 | Condition value zero-extended |

## Verification
The bench builds the unit with its default 32-bit data path. This makes all three width selects reachable, so carry and overflow can be driven out of bit 7, bit 15 and bit 31. Operands with junk above the selected width show that those bits are masked. A chained sequence runs compare, then test, then address-add, which shows which operations leave the flags or the result untouched. The signed and unsigned orderings of the same pair of operands separate the less-than conditions from the below conditions.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_AND = 3'd2,
        OP_OR  = 3'd3,
        OP_XOR = 3'd4,
        OP_CMP = 3'd5,
        OP_TST = 3'd6,
        OP_LEA = 3'd7
    } alu_op_e;

    typedef enum logic [1:0] {
        WD_8   = 2'd0,
        WD_16  = 2'd1,
        WD_32  = 2'd2,
        WD_32B = 2'd3
    } alu_width_e;

    typedef enum logic [3:0] {
        CC_EQ  = 4'd0,
        CC_NE  = 4'd1,
        CC_LT  = 4'd2,
        CC_GE  = 4'd3,
        CC_LE  = 4'd4,
        CC_GT  = 4'd5,
        CC_B   = 4'd6,
        CC_AE  = 4'd7,
        CC_BE  = 4'd8,
        CC_A   = 4'd9,
        CC_NEG = 4'd10,
        CC_POS = 4'd11
    } alu_cond_e;

    typedef struct packed {
        logic c;
        logic z;
        logic s;
        logic o;
    } alu_flags_t;

endpackage

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  alu_op_e             op,
    input  alu_width_e          width,
    input  logic [DATA_W-1:0]   a,
    input  logic [DATA_W-1:0]   b,
    output logic [DATA_W-1:0]   res,
    output alu_flags_t          flags,
    output logic                writes,
    output logic                sets_flags
);
    localparam int QW = (DATA_W >= 8)  ? 8  : DATA_W;
    localparam int HW = (DATA_W >= 16) ? 16 : DATA_W;

    logic [DATA_W-1:0] mask, top, am, bm;
    logic [DATA_W:0]   sum;
    logic [DATA_W-1:0] diff;
    logic              a_s, b_s, r_s, carry, ovf;

    always_comb begin
        unique case (width)
            WD_8:    mask = DATA_W'({QW{1'b1}});
            WD_16:   mask = DATA_W'({HW{1'b1}});
            default: mask = {DATA_W{1'b1}};
        endcase
        top  = mask ^ (mask >> 1);
        am   = a & mask;
        bm   = b & mask;
        sum  = {1'b0, am} + {1'b0, bm};
        diff = (am - bm) & mask;
        a_s  = |(am & top);
        b_s  = |(bm & top);
        res   = '0;
        carry = 1'b0;
        ovf   = 1'b0;
        unique case (op)
            OP_ADD, OP_LEA: begin
                res   = sum[DATA_W-1:0] & mask;
                carry = |(sum[DATA_W:1] & top);
            end
            OP_SUB, OP_CMP: begin
                res   = diff;
                carry = am < bm;
            end
            OP_AND, OP_TST: res = am & bm;
            OP_OR:          res = am | bm;
            default:        res = am ^ bm;
        endcase
        r_s = |(res & top);
        unique case (op)
            OP_ADD, OP_LEA: ovf = (a_s == b_s) && (r_s != a_s);
            OP_SUB, OP_CMP: ovf = (a_s != b_s) && (r_s != a_s);
            default:        ovf = 1'b0;
        endcase
        flags.c    = carry;
        flags.z    = (res == '0);
        flags.s    = r_s;
        flags.o    = ovf;
        writes     = !(op == OP_CMP || op == OP_TST);
        sets_flags = (op != OP_LEA);
    end

    always_comb begin
        assert (op != OP_CMP || !writes) else $error("assert_cmp_no_write_R6");
        assert (op != OP_LEA || !sets_flags) else $error("assert_lea_no_flags_R7");
    end
endmodule

// File: rtl/alu_cond.sv
module alu_cond
    import alu_pkg::*;
#(
    parameter int OUT_W = 32
) (
    input  alu_flags_t          flags,
    input  logic [3:0]          sel,
    output logic [7:0]          set_byte,
    output logic [OUT_W-1:0]    set_wide
);
    logic lt, hit;

    always_comb begin
        lt = flags.s ^ flags.o;
        unique case (sel)
            CC_EQ:   hit = flags.z;
            CC_NE:   hit = !flags.z;
            CC_LT:   hit = lt;
            CC_GE:   hit = !lt;
            CC_LE:   hit = lt | flags.z;
            CC_GT:   hit = !(lt | flags.z);
            CC_B:    hit = flags.c;
            CC_AE:   hit = !flags.c;
            CC_BE:   hit = flags.c | flags.z;
            CC_A:    hit = !(flags.c | flags.z);
            CC_NEG:  hit = flags.s;
            CC_POS:  hit = !flags.s;
            default: hit = 1'b0;
        endcase
        set_byte = {7'd0, hit};
        set_wide = {{(OUT_W-8){1'b0}}, set_byte};
    end

    always_comb begin
        assert (set_byte[7:1] == 7'd0) else $error("assert_byte_boolean_R10");
        assert (set_wide[OUT_W-1:8] == '0) else $error("assert_wide_upper_zero_R10");
    end
endmodule

// File: rtl/flag_alu.sv
module flag_alu
    import alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_valid,
    input  logic [2:0]          op_code,
    input  logic [1:0]          op_width,
    input  logic [DATA_W-1:0]   opnd_a,
    input  logic [DATA_W-1:0]   opnd_b,
    input  logic [3:0]          cond_sel,
    output logic [DATA_W-1:0]   result,
    output logic                result_we,
    output logic                flag_c,
    output logic                flag_z,
    output logic                flag_s,
    output logic                flag_o,
    output logic [7:0]          set_byte,
    output logic [DATA_W-1:0]   set_wide
);
    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              we;
        alu_flags_t        flags;
    } state_t;

    state_t            st_d, st_q;
    logic [DATA_W-1:0] core_res;
    alu_flags_t        core_flags;
    logic              core_writes, core_sets;

    alu_core #(.DATA_W(DATA_W)) u_core (
        .op         (alu_op_e'(op_code)),
        .width      (alu_width_e'(op_width)),
        .a          (opnd_a),
        .b          (opnd_b),
        .res        (core_res),
        .flags      (core_flags),
        .writes     (core_writes),
        .sets_flags (core_sets)
    );

    always_comb begin
        st_d    = st_q;
        st_d.we = op_valid && core_writes;
        if (op_valid && core_writes) st_d.res   = core_res;
        if (op_valid && core_sets)   st_d.flags = core_flags;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    alu_cond #(.OUT_W(DATA_W)) u_cond (
        .flags    (st_q.flags),
        .sel      (cond_sel),
        .set_byte (set_byte),
        .set_wide (set_wide)
    );

    assign result    = st_q.res;
    assign result_we = st_q.we;
    assign flag_c    = st_q.flags.c;
    assign flag_z    = st_q.flags.z;
    assign flag_s    = st_q.flags.s;
    assign flag_o    = st_q.flags.o;

    assert_cmp_tst_no_we_R6: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && (op_code == 3'd5 || op_code == 3'd6) |=> !result_we && $stable(result));
    assert_lea_flags_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_code == 3'd7 |=> $stable({flag_c, flag_z, flag_s, flag_o}) && result_we);
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !result_we && $stable(result) && $stable({flag_c, flag_z, flag_s, flag_o}));
    assert_byte_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_width == 2'd0 && op_code != 3'd5 && op_code != 3'd6
        |=> result[DATA_W-1:8] == '0);
    assert_zero_not_neg_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(flag_z && flag_s));
endmodule

// File: tb/flag_alu_test.sv
module flag_alu_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = '0;
    logic [1:0]  op_width = '0;
    logic [31:0] opnd_a = '0, opnd_b = '0;
    logic [3:0]  cond_sel = '0;
    logic [31:0] result, set_wide;
    logic        result_we, flag_c, flag_z, flag_s, flag_o;
    logic [7:0]  set_byte;

    int n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    flag_alu uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_width(op_width), .opnd_a(opnd_a), .opnd_b(opnd_b), .cond_sel(cond_sel),
        .result(result), .result_we(result_we), .flag_c(flag_c), .flag_z(flag_z),
        .flag_s(flag_s), .flag_o(flag_o), .set_byte(set_byte), .set_wide(set_wide)
    );

    // {op, width, a, b, expected result, expected we, expected {c,z,s,o}}
    typedef struct packed {
        logic [2:0]  op;
        logic [1:0]  wd;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] res;
        logic        we;
        logic [3:0]  fl;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 2'd2, 32'h1,        32'h2,        32'h3,        1'b1, 4'b0000}, // R3 plain add
        '{3'd0, 2'd2, 32'hFFFFFFFF, 32'h1,        32'h0,        1'b1, 4'b1100}, // R3 R4 carry+zero
        '{3'd0, 2'd2, 32'h7FFFFFFF, 32'h1,        32'h80000000, 1'b1, 4'b0011}, // R5 pos ovf
        '{3'd0, 2'd0, 32'h0000AB7F, 32'h0000CD01, 32'h80,       1'b1, 4'b0011}, // R2 R5 8-bit
        '{3'd0, 2'd0, 32'h000000FF, 32'h00000001, 32'h0,        1'b1, 4'b1100}, // R3 8-bit carry
        '{3'd0, 2'd1, 32'h00008000, 32'h00008000, 32'h0,        1'b1, 4'b1101}, // R5 16-bit neg ovf
        '{3'd1, 2'd2, 32'h5,        32'h7,        32'hFFFFFFFE, 1'b1, 4'b1010}, // R3 borrow
        '{3'd1, 2'd1, 32'hFFFF8000, 32'h00000001, 32'h7FFF,     1'b1, 4'b0001}, // R5 sub ovf
        '{3'd5, 2'd2, 32'h5,        32'h5,        32'h7FFF,     1'b0, 4'b0100}, // R6 cmp equal
        '{3'd2, 2'd2, 32'hF0F0F0F0, 32'hFF00FF00, 32'hF000F000, 1'b1, 4'b0010}, // R5 and
        '{3'd3, 2'd0, 32'h1234560F, 32'h000000F0, 32'hFF,       1'b1, 4'b0010}, // R2 or
        '{3'd4, 2'd1, 32'h00001234, 32'h00001234, 32'h0,        1'b1, 4'b0100}, // R4 xor zero
        '{3'd6, 2'd2, 32'h80000000, 32'h80000000, 32'h0,        1'b0, 4'b0010}, // R6 test
        '{3'd7, 2'd2, 32'h10,       32'h20,       32'h30,       1'b1, 4'b0010}, // R7 lea
        '{3'd5, 2'd0, 32'h1,        32'h2,        32'h30,       1'b0, 4'b1010}, // R6 cmp 8-bit
        '{3'd1, 2'd0, 32'h80,       32'h1,        32'h7F,       1'b1, 4'b0001}  // R5 8-bit sub ovf
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_op(input logic [2:0] op, input logic [1:0] wd,
                         input logic [31:0] a, input logic [31:0] b);
        op_valid = 1'b1; op_code = op; op_width = wd; opnd_a = a; opnd_b = b;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic chk_cond(input string req, input logic [3:0] sel, input logic exp);
        cond_sel = sel;
        #1;
        check(req, {24'd0, set_byte}, {31'd0, exp});
        check("R10 set_wide", set_wide, {31'd0, exp});
    endtask

    initial begin
        #1_000_000;
        n_fail++; n_chk++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 result", result, 32'h0);
        check("R1 we", {31'd0, result_we}, 32'h0);
        check("R1 flags", {28'd0, flag_c, flag_z, flag_s, flag_o}, 32'h0);
        chk_cond("R9 reset EQ", 4'd0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            do_op(VECS[i].op, VECS[i].wd, VECS[i].a, VECS[i].b);
            check($sformatf("R2-vec%0d result", i), result, VECS[i].res);
            check($sformatf("R6 R7 vec%0d we", i), {31'd0, result_we}, {31'd0, VECS[i].we});
            check($sformatf("R3 R4 R5 vec%0d flags", i),
                  {28'd0, flag_c, flag_z, flag_s, flag_o}, {28'd0, VECS[i].fl});
        end

        // R8: no valid -> hold, we low
        op_code = 3'd0; op_width = 2'd2; opnd_a = 32'hFFFFFFFF; opnd_b = 32'h1;
        @(negedge clk);
        check("R8 idle result", result, 32'h7F);
        check("R8 idle we", {31'd0, result_we}, 32'h0);
        check("R8 idle flags", {28'd0, flag_c, flag_z, flag_s, flag_o}, 32'h1);

        // R9: 3 vs 5, both signed and unsigned less
        do_op(3'd5, 2'd2, 32'h3, 32'h5);
        chk_cond("R9 EQ", 4'd0, 1'b0);
        chk_cond("R9 NE", 4'd1, 1'b1);
        chk_cond("R9 LT", 4'd2, 1'b1);
        chk_cond("R9 GE", 4'd3, 1'b0);
        chk_cond("R9 LE", 4'd4, 1'b1);
        chk_cond("R9 GT", 4'd5, 1'b0);
        chk_cond("R9 B",  4'd6, 1'b1);
        chk_cond("R9 AE", 4'd7, 1'b0);
        chk_cond("R9 BE", 4'd8, 1'b1);
        chk_cond("R9 A",  4'd9, 1'b0);
        chk_cond("R9 NEG", 4'd10, 1'b1);
        chk_cond("R9 POS", 4'd11, 1'b0);
        chk_cond("R9 undefined", 4'd15, 1'b0);

        // R9: -1 vs 1 signed less but unsigned above
        do_op(3'd5, 2'd2, 32'hFFFFFFFF, 32'h1);
        chk_cond("R9 signed LT", 4'd2, 1'b1);
        chk_cond("R9 unsigned B", 4'd6, 1'b0);
        chk_cond("R9 unsigned A", 4'd9, 1'b1);
        check("R6 cmp holds result", result, 32'h7F);

        // R9: equal at 16-bit with junk upper bits
        do_op(3'd5, 2'd1, 32'hAAAA0042, 32'h55550042);
        chk_cond("R9 R2 EQ masked", 4'd0, 1'b1);
        chk_cond("R9 BE on equal", 4'd8, 1'b1);
        chk_cond("R9 GT on equal", 4'd5, 1'b0);

        // R1: reset again clears everything
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 re-reset result", result, 32'h0);
        check("R1 re-reset flags", {28'd0, flag_c, flag_z, flag_s, flag_o}, 32'h0);
        rst_n = 1'b1;

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule